// File: doc/BRIEF.md
# Firmware Call and Return Sequencer

This block controls how a processor core enters and leaves its privileged firmware mode. When the core issues a firmware call with an 8-bit function code, the sequencer computes the firmware entry address from a base register. It records where to come back to, tagged with the mode the caller was in, switches firmware mode on and redirects the program counter. When the core issues a return, the sequencer takes a target value and restores both the program counter and the mode from it. The return also drops the interrupt-in-progress flag and releases any load-lock reservation.

The target of a return comes from one of two places: an operand supplied with the request, or the saved exception address. Instruction decode and the firmware code itself are outside this block. The core marks each event with a one-cycle strobe, and the sequencer commits all of its updates on that clock edge. The mode is held by a two-state machine. In `ST_NORMAL` the caller is unprivileged; in `ST_FIRMWARE` firmware mode is active. The machine has five named transitions:
- `T_ENTER` (normal to firmware, on a call)
- `T_NEST` (firmware to firmware, on a call)
- `T_EXIT` (firmware to normal, on a return whose target bit 0 is 0)
- `T_STAY` (firmware to firmware, on a return whose target bit 0 is 1)
- `T_PROMOTE` (normal to firmware, on a return whose target bit 0 is 1)

A return with target bit 0 equal to 0 taken in `ST_NORMAL` keeps that state (`T_IDLE`).

Top module: `fwseq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fw_mode` is 1, `next_pc` equals `fw_base`, `lock_addr` is all ones, `intr_flag` is 0 and `exc_addr` is 0.
- R2: A call whose code has bit 7 set loads `next_pc` with `fw_base + 0x2000 + (code - 0x80) * 64`, modulo 2^ADDR_W.
- R3: A call whose code has bit 7 clear loads `next_pc` with `fw_base + 0x1000 + code * 64`, modulo 2^ADDR_W.
- R4: A call loads `exc_addr` with `cur_pc` ORed with the value `fw_mode` had before the call, placed in bit 0.
- R5: After any call `fw_mode` is 1, including a call made while already in firmware mode. A call leaves `intr_flag` and `lock_addr` unchanged.
- R6: A return loads `next_pc` with its target value with bits 1:0 forced to 0.
- R7: A return loads `fw_mode` from bit 0 of its target value.
- R8: A return clears `intr_flag` and sets `lock_addr` to all ones, which means no lock is held. A return takes priority over `intr_set` and `lock_load` in the same cycle.
- R9: When `ret_use_exc` is 1, the return target is the current `exc_addr`, and `ret_target` is ignored. A return leaves `exc_addr` unchanged.
- R10: When `call_req` and `ret_req` are both 1, only the call takes effect: `intr_flag` and `lock_addr` are not touched by the return.
- R11: With no strobe, `next_pc`, `fw_mode` and `exc_addr` hold their values. `intr_set` sets `intr_flag`, and `lock_load` loads `lock_addr` from `lock_load_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fw_base | input | ADDR_W | Firmware base address |
| call_req | input | 1 | Firmware call strobe |
| call_code | input | 8 | Function code of the call |
| cur_pc | input | ADDR_W | Address of the calling instruction |
| ret_req | input | 1 | Firmware return strobe |
| ret_use_exc | input | 1 | Return takes its target from `exc_addr` |
| ret_target | input | ADDR_W | Return target operand |
| intr_set | input | 1 | Sets the interrupt-in-progress flag |
| lock_load | input | 1 | Loads a load-lock address |
| lock_load_addr | input | ADDR_W | Lock address to load |
| next_pc | output | ADDR_W | Redirected program counter |
| fw_mode | output | 1 | Firmware mode flag |
| exc_addr | output | ADDR_W | Saved return address with mode tag in bit 0 |
| intr_flag | output | 1 | Interrupt-in-progress flag |
| lock_addr | output | ADDR_W | Load-lock address, all ones when none is held |

## Verification
The bench builds the block with ADDR_W = 20 and the 8-bit function code. A narrow address keeps the arithmetic for the expected values easy to follow, and the chosen base value makes the largest entry offset wrap past 2^20, so the modulo behaviour is checked as well. All 256 function codes are swept. Even codes are called from normal mode, just after a return that clears the mode, and odd codes are called while firmware mode is still active. This covers both entry formulas, both values of the mode tag in `exc_addr`, and the `T_ENTER`, `T_NEST` and `T_EXIT` transitions. Directed steps then cover the remaining transitions, the two sources of the return target, a call and a return asserted together, and the flag and lock side effects.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;

    typedef enum logic {
        ST_NORMAL   = 1'b0,
        ST_FIRMWARE = 1'b1
    } fw_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2
    } fw_event_e;

endpackage

// File: rtl/fwseq_entry_calc.sv
module fwseq_entry_calc #(
    parameter int ADDR_W    = 64,
    parameter int CODE_W    = 8,
    parameter int SLOT_SH   = 6,
    parameter int LO_OFS    = 32'h1000,
    parameter int HI_OFS    = 32'h2000
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] entry
);
    localparam int IDX_W = CODE_W - 1;

    logic [ADDR_W-1:0] region_ofs;
    logic [ADDR_W-1:0] slot_ofs;

    always_comb begin
        region_ofs = code[CODE_W-1] ? ADDR_W'(HI_OFS) : ADDR_W'(LO_OFS);
        slot_ofs   = ADDR_W'(code[IDX_W-1:0]) << SLOT_SH;
        entry      = base + region_ofs + slot_ofs;
    end

endmodule

// File: rtl/fwseq_mode_fsm.sv
module fwseq_mode_fsm
    import fwseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fw_event_e ev,
    input  logic      ret_mode_bit,
    output logic      fw_mode
);
    fw_state_e state_q;
    fw_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (ev == EV_CALL)                     state_d = ST_FIRMWARE; // T_ENTER
                else if (ev == EV_RET && ret_mode_bit) state_d = ST_FIRMWARE; // T_PROMOTE
                else                                   state_d = ST_NORMAL;   // T_IDLE
            end
            ST_FIRMWARE: begin
                if (ev == EV_CALL)                      state_d = ST_FIRMWARE; // T_NEST
                else if (ev == EV_RET && !ret_mode_bit) state_d = ST_NORMAL;   // T_EXIT
                else                                    state_d = ST_FIRMWARE; // T_STAY
            end
            default: state_d = ST_FIRMWARE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FIRMWARE;
        else        state_q <= state_d;
    end

    always_comb begin
        fw_mode = (state_q == ST_FIRMWARE);
    end

    AST_CALL_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_CALL) |=> fw_mode); // R5

    AST_RET_LOADS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RET) |=> (fw_mode == $past(ret_mode_bit))); // R7

endmodule

// File: rtl/fwseq_top.sv
module fwseq_top
    import fwseq_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int CODE_W  = 8,
    parameter int SLOT_SH = 6,
    parameter int LO_OFS  = 32'h1000,
    parameter int HI_OFS  = 32'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fw_base,
    input  logic              call_req,
    input  logic [CODE_W-1:0] call_code,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              ret_req,
    input  logic              ret_use_exc,
    input  logic [ADDR_W-1:0] ret_target,
    input  logic              intr_set,
    input  logic              lock_load,
    input  logic [ADDR_W-1:0] lock_load_addr,
    output logic [ADDR_W-1:0] next_pc,
    output logic              fw_mode,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              intr_flag,
    output logic [ADDR_W-1:0] lock_addr
);
    localparam logic [ADDR_W-1:0] NO_LOCK  = '1;
    localparam logic [ADDR_W-1:0] ALIGN_MK = ~ADDR_W'(3);

    fw_event_e         ev;
    logic [ADDR_W-1:0] entry;
    logic [ADDR_W-1:0] ret_src;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] exc_q;
    logic              intr_q;
    logic [ADDR_W-1:0] lock_q;

    // Event arbitration: a call wins over a simultaneous return.
    always_comb begin
        if (call_req)     ev = EV_CALL;
        else if (ret_req) ev = EV_RET;
        else              ev = EV_NONE;
        ret_src = ret_use_exc ? exc_q : ret_target;
    end

    fwseq_entry_calc #(
        .ADDR_W  (ADDR_W),
        .CODE_W  (CODE_W),
        .SLOT_SH (SLOT_SH),
        .LO_OFS  (LO_OFS),
        .HI_OFS  (HI_OFS)
    ) entry_i (
        .base  (fw_base),
        .code  (call_code),
        .entry (entry)
    );

    fwseq_mode_fsm mode_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .ret_mode_bit (ret_src[0]),
        .fw_mode      (fw_mode)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= fw_base;
            exc_q <= '0;
        end else begin
            unique case (ev)
                EV_CALL: begin
                    pc_q  <= entry;
                    exc_q <= cur_pc | ADDR_W'(fw_mode);
                end
                EV_RET:  pc_q <= ret_src & ALIGN_MK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= 1'b0;
            lock_q <= NO_LOCK;
        end else if (ev == EV_RET) begin
            intr_q <= 1'b0;
            lock_q <= NO_LOCK;
        end else begin
            if (intr_set)  intr_q <= 1'b1;
            if (lock_load) lock_q <= lock_load_addr;
        end
    end

    always_comb begin
        next_pc   = pc_q;
        exc_addr  = exc_q;
        intr_flag = intr_q;
        lock_addr = lock_q;
    end

    AST_RET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> (next_pc[1:0] == 2'b00)); // R6

    AST_RET_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req) |=> (!intr_flag && lock_addr == NO_LOCK)); // R8

    AST_CALL_TAGS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> (exc_addr[0] == ($past(cur_pc[0]) | $past(fw_mode)))); // R4

    AST_CALL_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !lock_load) |=> $stable(lock_addr)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> ($stable(next_pc) && $stable(exc_addr))); // R11

endmodule

// File: tb/fwseq_tb_top.sv
module fwseq_top_tb_top;
    localparam int AW = 20;
    localparam logic [AW-1:0] BASE = 20'hFC5C4;
    localparam logic [AW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fw_base = BASE;
    logic          call_req = 1'b0;
    logic [7:0]    call_code = '0;
    logic [AW-1:0] cur_pc = '0;
    logic          ret_req = 1'b0;
    logic          ret_use_exc = 1'b0;
    logic [AW-1:0] ret_target = '0;
    logic          intr_set = 1'b0;
    logic          lock_load = 1'b0;
    logic [AW-1:0] lock_load_addr = '0;
    logic [AW-1:0] next_pc;
    logic          fw_mode;
    logic [AW-1:0] exc_addr;
    logic          intr_flag;
    logic [AW-1:0] lock_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwseq_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fw_base(fw_base),
        .call_req(call_req), .call_code(call_code), .cur_pc(cur_pc),
        .ret_req(ret_req), .ret_use_exc(ret_use_exc), .ret_target(ret_target),
        .intr_set(intr_set), .lock_load(lock_load), .lock_load_addr(lock_load_addr),
        .next_pc(next_pc), .fw_mode(fw_mode), .exc_addr(exc_addr),
        .intr_flag(intr_flag), .lock_addr(lock_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_entry(input int code);
        if (code >= 128) return AW'(BASE + 20'h2000 + AW'((code - 128) * 64));
        else             return AW'(BASE + 20'h1000 + AW'(code * 64));
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        call_req = 0; ret_req = 0; ret_use_exc = 0; intr_set = 0; lock_load = 0;
    endtask

    task automatic do_ret(input logic [AW-1:0] tgt, input logic alt);
        ret_req = 1; ret_target = tgt; ret_use_exc = alt;
        step();
    endtask

    task automatic do_call(input int code, input logic [AW-1:0] pc);
        call_req = 1; call_code = 8'(code); cur_pc = pc;
        step();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic          prev_mode;
        logic [AW-1:0] pc;
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk("R1 mode", 64'(fw_mode), 64'd1);
        chk("R1 pc", 64'(next_pc), 64'(BASE));
        rst_n = 1;
        @(negedge clk);
        chk("R1 lock", 64'(lock_addr), 64'(ONES));
        chk("R1 intr", 64'(intr_flag), 64'd0);
        chk("R1 exc", 64'(exc_addr), 64'd0);
        chk("R1 pc after", 64'(next_pc), 64'(BASE));

        // Full code sweep: even codes from normal mode, odd codes nested
        for (int c = 0; c < 256; c++) begin
            if (c % 2 == 0) begin
                do_ret(AW'(20'h00400 + c * 16), 1'b0);
                chk("R7 ret to normal", 64'(fw_mode), 64'd0);
                chk("R6 ret pc", 64'(next_pc), 64'(AW'(20'h00400 + c * 16)));
                intr_set = 1; lock_load = 1; lock_load_addr = AW'(c * 8 + 20'h80000);
                step();
            end
            prev_mode = fw_mode;
            pc = AW'(20'h40000 + c * 4);
            do_call(c, pc);
            if (c >= 128) chk("R2 entry high", 64'(next_pc), 64'(exp_entry(c)));
            else          chk("R3 entry low", 64'(next_pc), 64'(exp_entry(c)));
            chk("R4 exc tag", 64'(exc_addr), 64'(pc | AW'(prev_mode)));
            chk("R5 mode set", 64'(fw_mode), 64'd1);
            chk("R5 lock kept", 64'(lock_addr), 64'(AW'(c / 2 * 2 * 8 + 20'h80000)));
            chk("R5 intr kept", 64'(intr_flag), 64'd1);
        end

        // R6/R7: unaligned target, promote from normal mode
        do_ret(20'h01230, 1'b0);
        chk("R7 exit", 64'(fw_mode), 64'd0);
        do_ret(20'h0ABC7, 1'b0);
        chk("R6 align", 64'(next_pc), 64'h0ABC4);
        chk("R7 promote", 64'(fw_mode), 64'd1);
        do_ret(20'h0ABC5, 1'b0);
        chk("R7 stay", 64'(fw_mode), 64'd1);

        // R8: return wins over set/load in the same cycle
        intr_set = 1; lock_load = 1; lock_load_addr = 20'h01234;
        step();
        chk("R11 intr set", 64'(intr_flag), 64'd1);
        chk("R11 lock load", 64'(lock_addr), 64'h01234);
        ret_req = 1; ret_target = 20'h00800; intr_set = 1; lock_load = 1; lock_load_addr = 20'h05678;
        step();
        chk("R8 intr clear", 64'(intr_flag), 64'd0);
        chk("R8 lock released", 64'(lock_addr), 64'(ONES));

        // R9: alternative return through exc_addr (now normal mode)
        do_call(5, 20'h05550);
        chk("R9 exc saved", 64'(exc_addr), 64'h05550);
        do_ret(20'hFFFFF, 1'b1);
        chk("R9 pc from exc", 64'(next_pc), 64'h05550);
        chk("R9 mode from exc", 64'(fw_mode), 64'd0);
        chk("R9 exc kept", 64'(exc_addr), 64'h05550);
        do_call(200, 20'h06660);
        do_call(201, 20'h07770);
        chk("R9 nested tag", 64'(exc_addr), 64'h07771);
        do_ret(20'h00000, 1'b1);
        chk("R9 alt pc", 64'(next_pc), 64'h07770);
        chk("R9 alt mode", 64'(fw_mode), 64'd1);

        // R10: simultaneous call and return
        intr_set = 1; lock_load = 1; lock_load_addr = 20'h0BEEF;
        step();
        call_req = 1; call_code = 8'h83; cur_pc = 20'h02220;
        ret_req = 1; ret_target = 20'h00010;
        step();
        chk("R10 call pc", 64'(next_pc), 64'(exp_entry(131)));
        chk("R10 exc", 64'(exc_addr), 64'h02221);
        chk("R10 intr kept", 64'(intr_flag), 64'd1);
        chk("R10 lock kept", 64'(lock_addr), 64'h0BEEF);

        // R11: idle cycles hold state
        cur_pc = 20'h99990; ret_target = 20'h12345; call_code = 8'h11;
        repeat (4) step();
        chk("R11 pc hold", 64'(next_pc), 64'(exp_entry(131)));
        chk("R11 exc hold", 64'(exc_addr), 64'h02221);
        chk("R11 mode hold", 64'(fw_mode), 64'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule